// File: doc/BRIEF.md
# Telecom Bus Clock Output Controller

This block turns a master timing reference into the clocks and frame strobes that a telecom backplane needs. It runs on a core clock at twice the 16.384 MHz reference rate, which is 32.768 MHz. A free-running frame counter spans one 125 µs frame, which is 4096 core cycles. The counter's low bits give 16.384, 8.192, 4.096 and 2.048 MHz clocks. The same counter places the frame strobes at the start of each frame.

An 8-bit control word is loaded through a single-cycle write strobe, and it sets every output:
- which source drives the framer clock pin;
- whether the shared bus clock is a non-inverted 8.192 MHz clock or an inverted 4.096 MHz clock;
- how wide the compatibility frame pulse is;
- whether each of the two redundant clock/frame pairs drives its pins;
- how incoming bus clocks are to be read by neighbouring logic.

A per-pair clock-failure flag withdraws that pair's output enable whatever the control word says. Output enables are brought out as separate signals, so the pads can be tri-stated outside the block.

Top module: `busclk_ctl`

## Requirements
- R1: While reset is asserted, and after it, the control word is 0x00. Both pair enables and the framer enable are low, and the input-mode output is 0.
- R2: With control bits 7:5 = 000 the framer enable is low. With any other value it is high from the cycle after the write.
- R3: Framer select codes on bits 7:5: 001 drives the framer clock from the oscillator input, 010 drives it from the PLL input, and 011 drives it from a register that toggles on each rising PLL edge.
- R4: Let p be the number of core clock edges since reset release, modulo 4096. With select 100 the framer clock is high when p mod 16 < 8. With 101 it is high when p mod 8 < 4. With 110 it is high when p mod 4 < 2. With 111 it is high when p is even.
- R5: With control bit 1 = 1, the bus clock is high when p mod 4 < 2 (8.192 MHz, non-inverted). With bit 1 = 0, it is low when p mod 8 < 4 (inverted 4.096 MHz).
- R6: The bus frame is low exactly when p < 4. Clock and frame are identical on pair A and pair B.
- R7: The compatibility frame is low when p < 4 with control bit 0 = 0, and when p < 8 with bit 0 = 1.
- R8: Control bit 3 enables pair A and bit 2 enables pair B. Each enable takes effect one cycle after the write, independently of the other.
- R9: A high failure flag for a pair drives that pair's enable low on the next core edge, regardless of its enable bit. The other pair is unaffected.
- R10: The input-mode output follows control bit 4: 1 means incoming bus clocks are 8.192 MHz, and 0 means they are inverted 4.096 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 8 | Control word write data |
| oscIn | input | 1 | Oscillator source for the framer clock |
| pll2In | input | 1 | PLL source for the framer clock |
| failA | input | 1 | Latched clock failure flag for pair A |
| failB | input | 1 | Latched clock failure flag for pair B |
| framerClk | output | 1 | Selected framer clock |
| framerOe | output | 1 | Framer clock pad enable |
| busClkA | output | 1 | Pair A bus clock |
| busFrameA_n | output | 1 | Pair A frame, active low |
| pairOeA | output | 1 | Pair A pad enable |
| busClkB | output | 1 | Pair B bus clock |
| busFrameB_n | output | 1 | Pair B frame, active low |
| pairOeB | output | 1 | Pair B pad enable |
| compFrame_n | output | 1 | Compatibility frame, active low |
| inFast | output | 1 | Incoming bus clock interpretation |

## Verification
The assertions assume the following about the inputs:
- A failure flag is a level that is already synchronous to the core clock.
- Control writes are single-cycle strobes.
- Once the 16.384 MHz select has been held for two edges, nothing else changes it.

The stimulus keeps to these assumptions: it changes every input at the falling core edge, holds each failure flag for several cycles, and toggles the PLL input only while no phase check is running. The phase checks then compare each output against its formula in p across a whole frame wrap.

// File: rtl/busclk_pkg.sv
`timescale 1ns/1ps
package busclk_pkg;

  // Framer clock source codes; the numeric order is the software-visible encoding.
  typedef enum logic [2:0] {
    FS_TRI    = 3'd0,
    FS_OSC    = 3'd1,
    FS_PLL    = 3'd2,
    FS_PLLDIV = 3'd3,
    FS_C2     = 3'd4,
    FS_C4     = 3'd5,
    FS_C8     = 3'd6,
    FS_C16    = 3'd7
  } framerSrc_t;

  // Control word; packed MSB-first so it maps onto bits 7..0.
  typedef struct packed {
    framerSrc_t framerSel;  // 7:5
    logic       inFast;     // 4
    logic       enA;        // 3
    logic       enB;        // 2
    logic       busFast;    // 1
    logic       wideFrame;  // 0
  } ctrlReg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    framerSrc_t framerSel;
    logic       busFast;
    logic       wideFrame;
    logic       oeA;
    logic       oeB;
  } dpStrobe_t;

endpackage

// File: rtl/busclk_ctl_reg.sv
`timescale 1ns/1ps
module busclk_ctl_reg
  import busclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  input  logic       failA,
  input  logic       failB,
  output ctrlReg_t   ctrlQ,
  output dpStrobe_t  strobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWe) begin
      ctrlQ <= ctrlReg_t'(regWdata);
    end
  end

  // A failure flag overrides the software enable for its own pair only.
  always_comb begin
    strobe.framerSel = ctrlQ.framerSel;
    strobe.busFast   = ctrlQ.busFast;
    strobe.wideFrame = ctrlQ.wideFrame;
    strobe.oeA       = ctrlQ.enA & ~failA;
    strobe.oeB       = ctrlQ.enB & ~failB;
  end

endmodule

// File: rtl/busclk_ctl_dp.sv
`timescale 1ns/1ps
module busclk_ctl_dp
  import busclk_pkg::*;
#(
  parameter int FRAME_TICKS  = 4096,
  parameter int NARROW_TICKS = 4,
  parameter int NUM_TAPS     = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      oscIn,
  input  logic      pll2In,
  output logic      framerClk,
  output logic      framerOe,
  output logic      busClk,
  output logic      busFrame_n,
  output logic      compFrame_n,
  output logic      oeA,
  output logic      oeB
);

  localparam int CNT_W = $clog2(FRAME_TICKS);
  localparam logic [CNT_W-1:0] LAST_L   = CNT_W'(FRAME_TICKS - 1);
  localparam logic [CNT_W-1:0] NARROW_L = CNT_W'(NARROW_TICKS);
  localparam logic [CNT_W-1:0] WIDE_L   = CNT_W'(2 * NARROW_TICKS);

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cntNext;
  logic [NUM_TAPS-1:0] tap;   // tap[k]: rate 16.384 MHz >> k, high in first half
  logic                pllDivQ;
  logic                busFrameQ;
  logic                compFrameQ;
  logic                oeAQ;
  logic                oeBQ;

  assign cntNext = (cnt == LAST_L) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext;
    end
  end

  // Each tap is a single flop bit, so the derived clocks are glitch-free.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap[k] = ~cnt[k];
  end

  // Frame strobes are registered from the next count so they line up with cnt.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busFrameQ  <= 1'b0;
      compFrameQ <= 1'b0;
      oeAQ       <= 1'b0;
      oeBQ       <= 1'b0;
    end else begin
      busFrameQ  <= ~(cntNext < NARROW_L);
      compFrameQ <= ~(cntNext < (strobe.wideFrame ? WIDE_L : NARROW_L));
      oeAQ       <= strobe.oeA;
      oeBQ       <= strobe.oeB;
    end
  end

  // Halved PLL clock, in the PLL's own domain.
  always_ff @(posedge pll2In or negedge rstN) begin
    if (!rstN) begin
      pllDivQ <= 1'b0;
    end else begin
      pllDivQ <= ~pllDivQ;
    end
  end

  always_comb begin
    unique case (strobe.framerSel)
      FS_TRI:    framerClk = 1'b0;
      FS_OSC:    framerClk = oscIn;
      FS_PLL:    framerClk = pll2In;
      FS_PLLDIV: framerClk = pllDivQ;
      FS_C2:     framerClk = tap[3];
      FS_C4:     framerClk = tap[2];
      FS_C8:     framerClk = tap[1];
      FS_C16:    framerClk = tap[0];
      default:   framerClk = 1'b0;
    endcase
  end

  assign framerOe    = (strobe.framerSel != FS_TRI);
  assign busClk      = strobe.busFast ? tap[1] : ~tap[2];
  assign busFrame_n  = busFrameQ;
  assign compFrame_n = compFrameQ;
  assign oeA         = oeAQ;
  assign oeB         = oeBQ;

endmodule

// File: rtl/busclk_ctl.sv
`timescale 1ns/1ps
module busclk_ctl
  import busclk_pkg::*;
#(
  parameter int FRAME_TICKS  = 4096,
  parameter int NARROW_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  input  logic       oscIn,
  input  logic       pll2In,
  input  logic       failA,
  input  logic       failB,
  output logic       framerClk,
  output logic       framerOe,
  output logic       busClkA,
  output logic       busFrameA_n,
  output logic       pairOeA,
  output logic       busClkB,
  output logic       busFrameB_n,
  output logic       pairOeB,
  output logic       compFrame_n,
  output logic       inFast
);

  ctrlReg_t   ctrlQ;
  dpStrobe_t  strobe;
  logic [7:0] ctrlBits;
  logic       busClk;
  logic       busFrame_n;

  busclk_ctl_reg u_reg (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regWdata (regWdata),
    .failA    (failA),
    .failB    (failB),
    .ctrlQ    (ctrlQ),
    .strobe   (strobe)
  );

  busclk_ctl_dp #(
    .FRAME_TICKS  (FRAME_TICKS),
    .NARROW_TICKS (NARROW_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .oscIn       (oscIn),
    .pll2In      (pll2In),
    .framerClk   (framerClk),
    .framerOe    (framerOe),
    .busClk      (busClk),
    .busFrame_n  (busFrame_n),
    .compFrame_n (compFrame_n),
    .oeA         (pairOeA),
    .oeB         (pairOeB)
  );

  assign ctrlBits    = ctrlQ;
  assign inFast      = ctrlQ.inFast;
  assign busClkA     = busClk;
  assign busClkB     = busClk;
  assign busFrameA_n = busFrame_n;
  assign busFrameB_n = busFrame_n;

endmodule

// File: rtl/busclk_ctl_chk.sv
`timescale 1ns/1ps
module busclk_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       failA,
  input logic       failB,
  input logic       pairOeA,
  input logic       pairOeB,
  input logic [7:0] ctrlBits,
  input logic       compFrame_n,
  input logic       busFrameA_n,
  input logic       framerClk
);

  AST_FAIL_A_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    failA |=> !pairOeA);  // R9
  AST_FAIL_B_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    failB |=> !pairOeB);  // R9
  AST_OE_A_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    pairOeA |-> $past(ctrlBits[3]));  // R8
  AST_OE_B_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    pairOeB |-> $past(ctrlBits[2]));  // R8
  AST_COMP_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(compFrame_n) |-> ##3 !compFrame_n);  // R7
  AST_BUS_FRAME_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busFrameA_n) |-> ##3 !busFrameA_n);  // R6
  AST_C16_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[7:5] == 3'b111 && $past(ctrlBits[7:5]) == 3'b111)
      |-> framerClk != $past(framerClk));  // R4

endmodule

bind busclk_ctl busclk_ctl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .failA       (failA),
  .failB       (failB),
  .pairOeA     (pairOeA),
  .pairOeB     (pairOeB),
  .ctrlBits    (ctrlBits),
  .compFrame_n (compFrame_n),
  .busFrameA_n (busFrameA_n),
  .framerClk   (framerClk)
);

// File: tb/busclk_ctl_bench.sv
`timescale 1ns/1ps
module busclk_ctl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic       oscIn = 1'b0;
  logic       pll2In = 1'b0;
  logic       failA = 1'b0;
  logic       failB = 1'b0;
  logic       framerClk, framerOe, busClkA, busFrameA_n, pairOeA;
  logic       busClkB, busFrameB_n, pairOeB, compFrame_n, inFast;

  int         checks = 0;
  int         errors = 0;
  logic [11:0] p;

  always #10 clk = ~clk;

  busclk_ctl u_busclk_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .oscIn(oscIn), .pll2In(pll2In), .failA(failA), .failB(failB),
    .framerClk(framerClk), .framerOe(framerOe),
    .busClkA(busClkA), .busFrameA_n(busFrameA_n), .pairOeA(pairOeA),
    .busClkB(busClkB), .busFrameB_n(busFrameB_n), .pairOeB(pairOeB),
    .compFrame_n(compFrame_n), .inFast(inFast)
  );

  // Independent phase counter: edges since reset release, modulo one frame.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) p <= '0;
    else       p <= p + 12'd1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at p=%0d", tag, act, exp, p);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // {ctrl[7:0], failA, failB, expOeA, expOeB, expFramerOe}
  localparam int NVEC = 11;
  localparam logic [12:0] VEC [NVEC] = '{
    {8'h00, 2'b00, 3'b000},
    {8'h08, 2'b00, 3'b100},
    {8'h04, 2'b00, 3'b010},
    {8'h0C, 2'b00, 3'b110},
    {8'h0C, 2'b10, 3'b010},
    {8'h0C, 2'b01, 3'b100},
    {8'h0C, 2'b11, 3'b000},
    {8'h00, 2'b11, 3'b000},
    {8'h2C, 2'b00, 3'b111},
    {8'hE0, 2'b00, 3'b001},
    {8'h10, 2'b00, 3'b000}
  };

  // Compare every output against its phase formula over a span crossing a frame wrap.
  task automatic phaseRun(input logic [7:0] cfg, input int n);
    int eF, eB, eFr, eC;
    writeReg(cfg);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      case (cfg[7:5])
        3'd4: eF = (p % 16) < 8;
        3'd5: eF = (p % 8) < 4;
        3'd6: eF = (p % 4) < 2;
        3'd7: eF = (p % 2) == 0;
        default: eF = -1;
      endcase
      if (eF >= 0) chk("R4 framer clock", framerClk, eF);
      eB = cfg[1] ? ((p % 4) < 2) : !((p % 8) < 4);
      chk("R5 bus clock", busClkA, eB);
      eFr = !(p < 4);
      chk("R6 bus frame", busFrameA_n, eFr);
      chk("R6 pair B clock", busClkB, busClkA);
      chk("R6 pair B frame", busFrameB_n, busFrameA_n);
      eC = cfg[0] ? !(p < 8) : !(p < 4);
      chk("R7 compat frame", compFrame_n, eC);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic v0;
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk("R1 oeA in reset", pairOeA, 0);
    chk("R1 oeB in reset", pairOeB, 0);
    chk("R1 framerOe in reset", framerOe, 0);
    chk("R1 inFast in reset", inFast, 0);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R1 bus clock after reset", busClkA, !((p % 8) < 4));
      chk("R1 oeA after reset", pairOeA, 0);
      @(negedge clk);
    end

    // Vector table: R2 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      failA = VEC[i][4];
      failB = VEC[i][3];
      writeReg(VEC[i][12:5]);
      @(negedge clk);
      chk("R8/R9 pair A enable", pairOeA, VEC[i][2]);
      chk("R8/R9 pair B enable", pairOeB, VEC[i][1]);
      chk("R2 framer enable", framerOe, VEC[i][0]);
      chk("R10 input mode", inFast, VEC[i][9]);
    end
    failA = 1'b0;
    failB = 1'b0;

    // R9: failure drops only its own pair on the next edge
    writeReg(8'h0C);
    @(negedge clk);
    failA = 1'b1;
    @(negedge clk);
    chk("R9 failA next edge", pairOeA, 0);
    chk("R9 pair B kept", pairOeB, 1);
    failA = 1'b0;
    @(negedge clk);
    chk("R8 pair A back", pairOeA, 1);
    failB = 1'b1;
    @(negedge clk);
    chk("R9 failB next edge", pairOeB, 0);
    chk("R9 pair A kept", pairOeA, 1);
    failB = 1'b0;

    // R3: oscillator, PLL direct, PLL halved
    writeReg(8'h20);
    oscIn = 1'b1; #1;
    chk("R3 osc high", framerClk, 1);
    oscIn = 1'b0; #1;
    chk("R3 osc low", framerClk, 0);
    writeReg(8'h40);
    pll2In = 1'b1; #1;
    chk("R3 pll high", framerClk, 1);
    pll2In = 1'b0; #1;
    chk("R3 pll low", framerClk, 0);
    writeReg(8'h60);
    #1 v0 = framerClk;
    for (int k = 1; k <= 3; k++) begin
      pll2In = 1'b1; #1;
      chk("R3 pll halved rise", framerClk, (k % 2) ? !v0 : v0);
      pll2In = 1'b0; #1;
      chk("R3 pll halved hold", framerClk, (k % 2) ? !v0 : v0);
    end

    // R4..R7 across a frame wrap
    phaseRun(8'hE2, 4200);
    phaseRun(8'hC1, 4200);
    phaseRun(8'hA3, 4200);
    phaseRun(8'h80, 4200);
    phaseRun(8'h00, 64);

    // R1: reset in mid-run clears the control word
    writeReg(8'hFF);
    @(negedge clk);
    chk("R10 input mode set", inFast, 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 oeA after re-reset", pairOeA, 0);
    chk("R1 oeB after re-reset", pairOeB, 0);
    chk("R1 framerOe after re-reset", framerOe, 0);
    chk("R1 inFast after re-reset", inFast, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 stays clear", pairOeA, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule